// File: doc/BRIEF.md
# Rate-Halving Read Data Demultiplexer

This block sits on the read path of a memory physical layer, after the read data has been captured and moved onto a resync clock as single-rate words of width 2n. It rebuilds those words into half-rate words of width 4n on a PHY clock that runs at exactly half the resync frequency. Each output word places two consecutive input words side by side, with the later word in the upper half.

The conversion runs through a small dual-port storage array. Its write port is one single-rate word wide and is clocked by the resync clock. Its read port is two words wide and is clocked by the PHY clock. Both address pointers advance on every edge of their own clock and never stall. Both clocks come from one source with a fixed phase, so each output word trails its input words by a constant number of cycles. The read pointer starts a set number of half-rate entries behind the write pointer, which keeps reads away from entries that are being written.

A calibration sequencer drives `align_shift`, which chooses how the two words in each output are paired. A `hdr_valid` flag goes high a fixed number of PHY cycles after reset and stays high.

Top module: `rd_rate_demux`

## Requirements
- R1: While `rst_n` is low, every PHY clock edge clears `hdr_valid` to 0 and `hdr_data` to 0.
- R2: `hdr_valid` goes high after the (RD_OFFSET+3)th PHY edge that follows reset release. That is the 5th edge with the default RD_OFFSET=2. It then stays high until the next reset.
- R3: Input words are numbered j = 0, 1, 2, … from the first resync edge after reset release. Reset is released so that this edge comes half a resync period after the first PHY edge out of reset. With `align_shift` = 0, the output after PHY edge m ≥ 4 (edge 0 being the first after release) holds word 2m−6 in bits [2n−1:0] and word 2m−5 in bits [4n−1:2n].
- R4: With `align_shift` = 1, the output after PHY edge m ≥ 4 holds word 2m−7 in the lower half and word 2m−6 in the upper half. The pairing is shifted by one single-rate word.
- R5: `align_shift` is sampled on each PHY edge and sets the pairing of the word produced by that edge. After a change from 0 to 1, the new lower half equals the upper half of the word produced one PHY cycle before.
- R6: The pointers run freely and wrap with no stall. The relation in R3 and R4 therefore holds over any number of pointer wraps, and it holds again after any later reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sdr | input | 1 | Resync clock, single-rate write side |
| clk_hdr | input | 1 | PHY clock at half the resync frequency, read side |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| sdr_data | input | SDR_W | Single-rate read word (2n bits) |
| align_shift | input | 1 | Word pairing select from the sequencer (0: even/odd, 1: odd/even) |
| hdr_data | output | 2*SDR_W | Half-rate read word, later word in the upper half |
| hdr_valid | output | 1 | High once the pipeline holds written data |

## Verification
The hardest situation to reach is the exact moment a pairing change takes effect. The shifted word has to be built from the word read one PHY cycle earlier, so a one-cycle slip in the history register produces plausible data that looks nearly correct. The stimulus reaches this case by toggling `align_shift` between PHY edges every few cycles while an incrementing pattern streams in. Every output word is then checked against its exact input indices. Long runs make the pointers wrap many times, and a reset in the middle of a run confirms that the same latency returns.

// File: rtl/rd_rate_demux_pkg.sv
// Shared definitions for the rate-halving read demultiplexer.
package rd_rate_demux_pkg;

    // Pairing of single-rate words inside one half-rate word.
    typedef enum logic {
        PAIR_EVEN_FIRST = 1'b0,   // words (2k, 2k+1)
        PAIR_ODD_FIRST  = 1'b1    // words (2k+1, 2k+2)
    } pair_mode_e;

    // PHY cycles after reset release until the aligned output holds written data.
    function automatic int unsigned warmup_cycles(input int unsigned rd_offset);
        return rd_offset + 3;
    endfunction

endpackage

// File: rtl/rdm_wr_ptr.sv
// Write-side address pointer.
// Does: advances one entry on every resync edge once out of reset.
// Assumes: rst_n is synchronous to clk_sdr; no flow control exists.
module rdm_wr_ptr #(
    parameter int unsigned WR_AW = 3
) (
    input  logic             clk_sdr,
    input  logic             rst_n,
    output logic [WR_AW-1:0] wr_addr,
    output logic             wr_en
);

    // Free-running pointer; it returns to entry 0 on reset.
    always_ff @(posedge clk_sdr) begin
        if (!rst_n) wr_addr <= '0;
        else        wr_addr <= wr_addr + 1'b1;
    end

    assign wr_en = rst_n;

endmodule

// File: rtl/rdm_dpram.sv
// Asymmetric dual-clock storage array.
// Does: writes one W-bit entry per clk_w edge and reads two adjacent
//       entries {odd, even} as one 2W-bit word per clk_r edge (registered).
// Assumes: the caller keeps read and write addresses apart; no collision logic.
module rdm_dpram #(
    parameter int unsigned W     = 16,
    parameter int unsigned WR_AW = 3
) (
    input  logic             clk_w,
    input  logic             we,
    input  logic [WR_AW-1:0] wa,
    input  logic [W-1:0]     wd,
    input  logic             clk_r,
    input  logic             rst_n,
    input  logic [WR_AW-2:0] ra,
    output logic [2*W-1:0]   rd
);

    localparam int unsigned DEPTH = 1 << WR_AW;

    logic [W-1:0] mem [DEPTH];

    // Write port: store one single-rate word.
    always_ff @(posedge clk_w) begin
        if (we) mem[wa] <= wd;
    end

    // Read port: one registered lane per half of the wide word.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam logic [0:0] LANE = 1'(g);
        logic [W-1:0] lane_q;

        // Capture the entry for this lane; cleared under reset.
        always_ff @(posedge clk_r) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= mem[{ra, LANE}];
        end

        assign rd[g*W +: W] = lane_q;
    end

endmodule

// File: rtl/rdm_rd_ctrl.sv
// Read-side control.
// Does: runs the wide-word read pointer, which starts RD_OFFSET entries
//       behind the write pointer, and raises a sticky valid flag after a
//       fixed warm-up count.
// Assumes: rst_n is synchronous to clk_hdr and released in fixed phase
//          with the write side.
module rdm_rd_ctrl
    import rd_rate_demux_pkg::*;
#(
    parameter int unsigned RD_AW     = 2,
    parameter int unsigned RD_OFFSET = 2
) (
    input  logic             clk_hdr,
    input  logic             rst_n,
    output logic [RD_AW-1:0] rd_addr,
    output logic             data_valid
);

    localparam int unsigned HALF_DEPTH = 1 << RD_AW;
    localparam int unsigned WARMUP     = warmup_cycles(RD_OFFSET);
    localparam int unsigned CNT_W      = $clog2(WARMUP + 1);
    localparam logic [RD_AW-1:0] RP_INIT = RD_AW'(HALF_DEPTH - RD_OFFSET);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WARMUP);

    logic [CNT_W-1:0] warm_cnt;

    // Free-running read pointer that trails the write side.
    always_ff @(posedge clk_hdr) begin
        if (!rst_n) rd_addr <= RP_INIT;
        else        rd_addr <= rd_addr + 1'b1;
    end

    // Count warm-up edges and hold at the end value.
    always_ff @(posedge clk_hdr) begin
        if (!rst_n)                warm_cnt <= '0;
        else if (warm_cnt != CNT_END) warm_cnt <= warm_cnt + 1'b1;
    end

    assign data_valid = (warm_cnt == CNT_END);

endmodule

// File: rtl/rdm_aligner.sv
// Word-pairing stage.
// Does: keeps the previous wide read and, when shifted pairing is chosen,
//       joins the upper half of that read with the lower half of the current one.
// Assumes: raw words arrive one per clk_hdr edge with no gaps.
module rdm_aligner
    import rd_rate_demux_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic           clk_hdr,
    input  logic           rst_n,
    input  logic [2*W-1:0] raw_word,
    input  logic           align_shift,
    output logic [2*W-1:0] out_word
);

    pair_mode_e     mode;
    logic [2*W-1:0] prev_word;
    logic [2*W-1:0] next_word;

    assign mode = pair_mode_e'(align_shift);

    // Choose the pairing for the word leaving on this edge.
    always_comb begin
        if (mode == PAIR_ODD_FIRST) next_word = {raw_word[W-1:0], prev_word[2*W-1:W]};
        else                        next_word = raw_word;
    end

    // Keep one wide read of history for the shifted pairing.
    always_ff @(posedge clk_hdr) begin
        if (!rst_n) prev_word <= '0;
        else        prev_word <= raw_word;
    end

    // Register the aligned output.
    always_ff @(posedge clk_hdr) begin
        if (!rst_n) out_word <= '0;
        else        out_word <= next_word;
    end

endmodule

// File: rtl/rd_rate_demux.sv
// Rate-halving read data demultiplexer (top).
// Does: turns single-rate SDR_W words on clk_sdr into 2*SDR_W words on
//       clk_hdr at a constant latency, with sequencer-selected pairing.
// Assumes: clk_hdr is half the frequency of clk_sdr from the same source, with
//          a fixed phase; rst_n leaves reset so that the first clk_sdr edge out
//          of reset comes half a clk_sdr period after the first clk_hdr edge.
module rd_rate_demux #(
    parameter int unsigned SDR_W     = 16,
    parameter int unsigned WR_AW     = 3,
    parameter int unsigned RD_OFFSET = 2
) (
    input  logic               clk_sdr,
    input  logic               clk_hdr,
    input  logic               rst_n,
    input  logic [SDR_W-1:0]   sdr_data,
    input  logic               align_shift,
    output logic [2*SDR_W-1:0] hdr_data,
    output logic               hdr_valid
);

    localparam int unsigned RD_AW = WR_AW - 1;

    logic [WR_AW-1:0]   wr_addr;
    logic               wr_en;
    logic [RD_AW-1:0]   rd_addr;
    logic [2*SDR_W-1:0] raw_word;

    rdm_wr_ptr #(.WR_AW(WR_AW)) u_wr_ptr (
        .clk_sdr (clk_sdr),
        .rst_n   (rst_n),
        .wr_addr (wr_addr),
        .wr_en   (wr_en)
    );

    rdm_dpram #(.W(SDR_W), .WR_AW(WR_AW)) u_ram (
        .clk_w (clk_sdr),
        .we    (wr_en),
        .wa    (wr_addr),
        .wd    (sdr_data),
        .clk_r (clk_hdr),
        .rst_n (rst_n),
        .ra    (rd_addr),
        .rd    (raw_word)
    );

    rdm_rd_ctrl #(.RD_AW(RD_AW), .RD_OFFSET(RD_OFFSET)) u_rd_ctrl (
        .clk_hdr    (clk_hdr),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr),
        .data_valid (hdr_valid)
    );

    rdm_aligner #(.W(SDR_W)) u_align (
        .clk_hdr     (clk_hdr),
        .rst_n       (rst_n),
        .raw_word    (raw_word),
        .align_shift (align_shift),
        .out_word    (hdr_data)
    );

endmodule

// File: rtl/rd_rate_demux_chk.sv
// Assertion checker for rd_rate_demux, attached by bind.
module rd_rate_demux_chk
    import rd_rate_demux_pkg::*;
#(
    parameter int unsigned SDR_W     = 16,
    parameter int unsigned RD_OFFSET = 2
) (
    input logic               clk_hdr,
    input logic               rst_n,
    input logic               align_shift,
    input logic [2*SDR_W-1:0] hdr_data,
    input logic               hdr_valid
);

    localparam int unsigned WARMUP = warmup_cycles(RD_OFFSET);

    int unsigned edges_seen;

    // Count PHY edges since reset release, holding at the warm-up limit.
    always_ff @(posedge clk_hdr) begin
        if (!rst_n)                  edges_seen <= 0;
        else if (edges_seen < WARMUP) edges_seen <= edges_seen + 1;
    end

    // R1: reset clears the output and valid.
    assert_reset_clear_R1: assert property (@(posedge clk_hdr)
        !rst_n |=> (!hdr_valid && hdr_data == '0));

    // R2: valid matches the warm-up window.
    assert_valid_window_R2: assert property (@(posedge clk_hdr) disable iff (!rst_n)
        hdr_valid == (edges_seen >= WARMUP));

    // R2: valid never drops outside reset.
    assert_valid_sticky_R2: assert property (@(posedge clk_hdr) disable iff (!rst_n)
        hdr_valid |=> hdr_valid);

    // R5: switching to shifted pairing reuses the previous upper word.
    assert_shift_switch_R5: assert property (@(posedge clk_hdr) disable iff (!rst_n)
        (hdr_valid && align_shift && !$past(align_shift))
        |=> hdr_data[SDR_W-1:0] == $past(hdr_data[2*SDR_W-1:SDR_W]));

endmodule

bind rd_rate_demux rd_rate_demux_chk #(.SDR_W(SDR_W), .RD_OFFSET(RD_OFFSET)) u_chk (
    .clk_hdr     (clk_hdr),
    .rst_n       (rst_n),
    .align_shift (align_shift),
    .hdr_data    (hdr_data),
    .hdr_valid   (hdr_valid)
);

// File: tb/rd_rate_demux_tb.sv
`timescale 1ns/100ps
module rd_rate_demux_tb;

    localparam int W = 16;

    logic          clk_sdr = 1'b0;
    logic          clk_hdr = 1'b0;
    logic          rst_n   = 1'b0;
    logic [W-1:0]  sdr_data = '0;
    logic          align_shift = 1'b0;
    logic [2*W-1:0] hdr_data;
    logic          hdr_valid;

    int checks = 0;
    int errors = 0;
    int wcnt   = 0;   // words driven since release
    int hcnt   = 0;   // PHY edges since release
    bit done   = 0;

    rd_rate_demux u_dut (
        .clk_sdr     (clk_sdr),
        .clk_hdr     (clk_hdr),
        .rst_n       (rst_n),
        .sdr_data    (sdr_data),
        .align_shift (align_shift),
        .hdr_data    (hdr_data),
        .hdr_valid   (hdr_valid)
    );

    // 200 MHz resync clock; PHY clock at half rate, rising 2.5 ns after a resync rise.
    initial begin
        #2.5;
        forever begin clk_sdr = 1'b1; #2.5; clk_sdr = 1'b0; #2.5; end
    end
    initial begin
        #5;
        forever begin clk_hdr = 1'b1; #5; clk_hdr = 1'b0; #5; end
    end

    function automatic logic [W-1:0] word_val(input int j);
        return W'(16'h1000 + j);
    endfunction

    // Stream the incrementing pattern, one word per resync cycle.
    initial forever begin
        @(negedge clk_sdr);
        if (rst_n) begin sdr_data = word_val(wcnt); wcnt++; end
    end

    // Count PHY edges since release.
    initial forever begin
        @(posedge clk_hdr);
        if (rst_n) hcnt++;
    end

    task automatic report_check(input bit ok, input string req, input logic [2*W-1:0] act,
                                input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reset, check cleared outputs, then release in the required phase.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk_hdr);
        report_check(hdr_valid == 1'b0, "R1 valid", {31'd0, hdr_valid}, '0);
        report_check(hdr_data == '0, "R1 data", hdr_data, '0);
        wcnt = 0;
        hcnt = 0;
        @(negedge clk_hdr);
        @(posedge clk_sdr);
        #1 rst_n = 1'b1;
    endtask

    // Sample after the next PHY edge and check data and valid.
    task automatic sample_one(input string req);
        int m;
        logic [2*W-1:0] exp;
        @(negedge clk_hdr);
        m = hcnt - 1;
        report_check(hdr_valid == (m >= 4), "R2 valid", {31'd0, hdr_valid}, {31'd0, m >= 4});
        if (m >= 4) begin
            if (align_shift) exp = {word_val(2*m-6), word_val(2*m-7)};
            else             exp = {word_val(2*m-5), word_val(2*m-6)};
            report_check(hdr_data == exp, req, hdr_data, exp);
        end
    endtask

    // R1, R2: reset state and warm-up of the valid flag.
    task automatic t_reset_warmup();
        align_shift = 1'b0;
        do_reset();
        for (int i = 0; i < 8; i++) sample_one("R3 warmup");
    endtask

    // R3, R6: even pairing over many pointer wraps.
    task automatic t_even_pairing();
        align_shift = 1'b0;
        for (int i = 0; i < 40; i++) sample_one("R3 even pairing");
    endtask

    // R4, R6: odd pairing over many pointer wraps.
    task automatic t_odd_pairing();
        @(negedge clk_hdr);
        align_shift = 1'b1;
        for (int i = 0; i < 40; i++) sample_one("R4 odd pairing");
    endtask

    // R5: toggle pairing between edges; each change applies at the next edge.
    task automatic t_switching();
        for (int i = 0; i < 30; i++) begin
            if (i % 3 == 0) align_shift = ~align_shift;
            sample_one("R5 switch");
        end
    endtask

    // R6: reset in mid-run; the same latency returns.
    task automatic t_rereset();
        align_shift = 1'b1;
        do_reset();
        for (int i = 0; i < 20; i++) sample_one("R6 after reset");
        align_shift = 1'b0;
        for (int i = 0; i < 20; i++) sample_one("R6 after reset even");
    endtask

    initial begin
        t_reset_warmup();
        t_even_pairing();
        t_odd_pairing();
        t_switching();
        t_rereset();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule